// File: doc/BRIEF.md
# Phase-Slewing Dual Clock Divider

This block derives two clock enables from one master clock. A fast lane divides the master clock by 4. A slow lane alternates between dividing by 19 and dividing by 18. Each lane emits a one-cycle tick in the last master cycle of every output period. A receiver uses the two ticks to time its sampling. When the receiver needs to move its sampling instant to a new symbol position, it writes a signed step count over a one-cycle write strobe.

The block does not jump the phase in a single step. It alters a run of consecutive output periods in each lane, changing every altered period by exactly one master cycle. The number of altered periods equals the magnitude of the written value. A negative value lengthens the periods and so delays both ticks. A positive value shortens them and so advances both ticks. Each lane keeps its own down-counter, so the slow lane needs more master cycles than the fast lane to finish. Both lanes still move by the same total number of master cycles, which keeps their relative phase unchanged. A busy output stays high until both lanes have finished.

Top module: `phase_slew_divider`

## Requirements
- R1: When no adjustment is active, `fastTick` pulses for one master cycle in every 4 master cycles.
- R2: When no adjustment is active, the slow periods alternate 19, 18, 19, 18 master cycles. The first period after reset is 19. This alternation keeps stepping on every period, including altered ones.
- R3: For a negative write value, each altered period is one master cycle longer than its unaltered length: 5 in the fast lane, and 20 or 19 in the slow lane.
- R4: For a positive write value, each altered period is one master cycle shorter than its unaltered length: 3 in the fast lane, and 18 or 17 in the slow lane.
- R5: In each lane, the number of altered periods equals the magnitude of the value. The altered run starts with the first period that begins after the write cycle, and the altered periods are consecutive.
- R6: When an adjustment finishes, each lane has moved by exactly minus the written value in master cycles (the sum of period length minus unaltered length), and both lanes have moved by the same amount.
- R7: `busy` is low after reset. It rises in the cycle after an accepted write and stays high until both lanes have finished their altered periods.
- R8: A write while `busy` is high is ignored and does not change the adjustment that is running.
- R9: A write of zero is ignored: `busy` stays low and the periods stay unaltered.
- R10: After reset both lanes are in unaltered mode, `busy` is low, and no tick is asserted in the first cycle.
- R11: The most negative value (-2^(ADJ_W-1), which is -128 by default) is accepted and produces 2^(ADJ_W-1) lengthened periods in each lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | One-cycle write strobe for the adjust value |
| wrData | input | ADJ_W | Signed two's-complement adjust value |
| fastTick | output | 1 | Fast-lane enable, high in the last cycle of each period |
| slowTick | output | 1 | Slow-lane enable, high in the last cycle of each period |
| busy | output | 1 | High while either lane still has altered periods pending or running |

## Verification
The hardest case to reach from the ports is a write that arrives while the fast lane has already finished but the slow lane is still slewing. In that window `busy` is high only because of the slow counter. The write must be dropped without disturbing the remaining slow periods. The directed sequence issues a second write ten cycles into a run, and long constrained-random gaps between signed writes land other writes in the tail where only the slow lane is still active. A bench model of period lengths checks every period of both lanes, as well as the accumulated shift at the end of each run.

// File: rtl/slew_pkg.sv
package slew_pkg;

  // Mode strobes from control to datapath, sampled at each lane's period boundary
  typedef struct packed {
    logic fastLong;
    logic fastShort;
    logic slowLong;
    logic slowShort;
  } slewStrobes_t;

endpackage

// File: rtl/slew_divider.sv
module slew_divider #(
  parameter int BASE_A = 19,
  parameter int BASE_B = 18
) (
  input  logic clk,
  input  logic rstN,
  input  logic lengthen,
  input  logic shorten,
  output logic tick
);

  localparam int  MAX_MOD   = ((BASE_A > BASE_B) ? BASE_A : BASE_B) + 1;
  localparam int  MIN_MOD   = ((BASE_A < BASE_B) ? BASE_A : BASE_B) - 1;
  localparam int  CW        = $clog2(MAX_MOD + 1);
  localparam bit  ALTERNATE = (BASE_A != BASE_B);

  logic [CW-1:0] pos;
  logic [CW-1:0] curMod;
  logic [CW-1:0] nextBase;
  logic [CW-1:0] nextMod;
  logic          sel;
  logic          nextSel;

  generate
    if (ALTERNATE) begin : g_alt
      always_ff @(posedge clk) begin
        if (!rstN)     sel <= 1'b0;
        else if (tick) sel <= ~sel;
      end
      assign nextSel = ~sel;

      // R2
      alt_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
        tick |=> (sel != $past(sel)));
    end else begin : g_fixed
      assign sel     = 1'b0;
      assign nextSel = 1'b0;
    end
  endgenerate

  assign nextBase = nextSel ? CW'(BASE_B) : CW'(BASE_A);

  always_comb begin
    nextMod = nextBase;
    if (lengthen)     nextMod = nextBase + CW'(1);
    else if (shorten) nextMod = nextBase - CW'(1);
  end

  assign tick = (pos == curMod - CW'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos    <= '0;
      curMod <= CW'(BASE_A);
    end else if (tick) begin
      pos    <= '0;
      curMod <= nextMod;
    end else begin
      pos    <= pos + CW'(1);
    end
  end

  // R3 R4
  mod_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> (int'(curMod) >= MIN_MOD && int'(curMod) <= MAX_MOD));

  // R1 R2
  period_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(curMod));

  // R5
  excl_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({lengthen, shorten}));

endmodule

// File: rtl/slew_datapath.sv
module slew_datapath
  import slew_pkg::*;
#(
  parameter int FAST_DIV   = 4,
  parameter int SLOW_DIV_A = 19,
  parameter int SLOW_DIV_B = 18
) (
  input  logic         clk,
  input  logic         rstN,
  input  slewStrobes_t strobes,
  output logic         fastTick,
  output logic         slowTick
);

  slew_divider #(.BASE_A(FAST_DIV), .BASE_B(FAST_DIV)) u_fastDiv (
    .clk      (clk),
    .rstN     (rstN),
    .lengthen (strobes.fastLong),
    .shorten  (strobes.fastShort),
    .tick     (fastTick)
  );

  slew_divider #(.BASE_A(SLOW_DIV_A), .BASE_B(SLOW_DIV_B)) u_slowDiv (
    .clk      (clk),
    .rstN     (rstN),
    .lengthen (strobes.slowLong),
    .shorten  (strobes.slowShort),
    .tick     (slowTick)
  );

endmodule

// File: rtl/slew_ctrl.sv
module slew_ctrl
  import slew_pkg::*;
#(
  parameter int ADJ_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [ADJ_W-1:0] wrData,
  input  logic             fastTick,
  input  logic             slowTick,
  output slewStrobes_t     strobes,
  output logic             busy
);

  localparam int LANES = 2;

  logic [ADJ_W-1:0] magReg;
  logic [ADJ_W-1:0] wrMag;
  logic             dirLong;
  logic             accept;
  logic             laneTick   [LANES];
  logic             pend       [LANES];
  logic             alterNext  [LANES];
  logic             laneActive [LANES];
  logic [ADJ_W-1:0] cnt        [LANES];
  logic [ADJ_W-1:0] nextCnt    [LANES];

  assign laneTick[0] = fastTick;
  assign laneTick[1] = slowTick;

  assign wrMag  = wrData[ADJ_W-1] ? (~wrData + ADJ_W'(1)) : wrData;
  assign busy   = laneActive[0] | laneActive[1];
  assign accept = wrEn && !busy && (wrData != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      magReg  <= '0;
      dirLong <= 1'b0;
    end else if (accept) begin
      magReg  <= wrMag;
      dirLong <= wrData[ADJ_W-1];
    end
  end

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign laneActive[i] = pend[i] | (cnt[i] != '0);

      always_comb begin
        if (pend[i])             nextCnt[i] = magReg;
        else if (cnt[i] != '0)   nextCnt[i] = cnt[i] - ADJ_W'(1);
        else                     nextCnt[i] = '0;
        alterNext[i] = (nextCnt[i] != '0);
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          pend[i] <= 1'b0;
          cnt[i]  <= '0;
        end else begin
          if (accept)           pend[i] <= 1'b1;
          else if (laneTick[i]) pend[i] <= 1'b0;
          if (laneTick[i])      cnt[i]  <= nextCnt[i];
        end
      end

      // R5
      cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        !laneTick[i] |=> $stable(cnt[i]));

      // R5
      cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
        (laneTick[i] && !pend[i] && cnt[i] != '0) |=> (cnt[i] == $past(cnt[i]) - ADJ_W'(1)));
    end
  endgenerate

  assign strobes.fastLong  = alterNext[0] &  dirLong;
  assign strobes.fastShort = alterNext[0] & ~dirLong;
  assign strobes.slowLong  = alterNext[1] &  dirLong;
  assign strobes.slowShort = alterNext[1] & ~dirLong;

  // R8
  ignore_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busy) |=> ($stable(magReg) && $stable(dirLong)));

  // R7
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> busy);

  // R9
  zero_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !busy && wrData == '0) |=> !busy);

endmodule

// File: rtl/phase_slew_divider.sv
module phase_slew_divider
  import slew_pkg::*;
#(
  parameter int ADJ_W      = 8,
  parameter int FAST_DIV   = 4,
  parameter int SLOW_DIV_A = 19,
  parameter int SLOW_DIV_B = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [ADJ_W-1:0] wrData,
  output logic             fastTick,
  output logic             slowTick,
  output logic             busy
);

  slewStrobes_t strobes;

  slew_ctrl #(.ADJ_W(ADJ_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .fastTick (fastTick),
    .slowTick (slowTick),
    .strobes  (strobes),
    .busy     (busy)
  );

  slew_datapath #(
    .FAST_DIV   (FAST_DIV),
    .SLOW_DIV_A (SLOW_DIV_A),
    .SLOW_DIV_B (SLOW_DIV_B)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .fastTick (fastTick),
    .slowTick (slowTick)
  );

endmodule

// File: tb/phase_slew_divider_tb.sv
module phase_slew_divider_tb;

  localparam int ADJ_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic [ADJ_W-1:0] wrData = '0;
  logic             fastTick;
  logic             slowTick;
  logic             busy;

  always #10 clk = ~clk;

  phase_slew_divider #(.ADJ_W(ADJ_W)) u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .fastTick (fastTick),
    .slowTick (slowTick),
    .busy     (busy)
  );

  int checks = 0;
  int failures = 0;

  bit mPend [2];
  int mRem [2];
  bit mAlt [2];
  int mPhase [2];
  int mCyc [2];
  int mDev [2];
  int doneDev [2];
  bit mDirLong;
  int mMag;
  int mVal;
  bit mFirst = 1'b1;

  function automatic int baseLen(int lane, int ph);
    if (lane == 0) return 4;
    return (ph == 0) ? 19 : 18;
  endfunction

  function automatic bit modelBusy();
    return mPend[0] | mPend[1] | (mRem[0] != 0) | (mRem[1] != 0);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(bit doWr, int val);
    bit busyM;
    @(negedge clk);
    busyM = modelBusy();
    if (mFirst) begin
      chk(!busy && !fastTick && !slowTick, "R10", {busy, fastTick, slowTick}, 0);
      mFirst = 1'b0;
    end
    chk(busy == busyM, "R7", busy, busyM);
    for (int lane = 0; lane < 2; lane++) begin
      bit t;
      int expLen;
      string tag;
      t = (lane == 0) ? fastTick : slowTick;
      mCyc[lane]++;
      expLen = baseLen(lane, mPhase[lane]) + (mAlt[lane] ? (mDirLong ? 1 : -1) : 0);
      tag = mAlt[lane] ? (mDirLong ? "R3 R5" : "R4 R5") : ((lane == 0) ? "R1" : "R2");
      if (t) begin
        chk(mCyc[lane] == expLen, tag, mCyc[lane], expLen);
        if (mAlt[lane]) mDev[lane] += mCyc[lane] - baseLen(lane, mPhase[lane]);
        if (mPend[lane]) begin
          mRem[lane] = mMag;
          mPend[lane] = 1'b0;
        end else if (mRem[lane] > 0) begin
          mRem[lane]--;
          if (mRem[lane] == 0) begin
            chk(mDev[lane] == -mVal, "R6", mDev[lane], -mVal);
            doneDev[lane] = mDev[lane];
          end
        end
        mAlt[lane] = (mRem[lane] != 0);
        if (lane == 1) mPhase[lane] ^= 1;
        mCyc[lane] = 0;
      end else if (mCyc[lane] == expLen) begin
        chk(1'b0, tag, mCyc[lane], expLen);
      end
    end
    if (doWr) begin
      wrEn = 1'b1;
      wrData = val[ADJ_W-1:0];
      if (!busyM && val != 0) begin
        mPend[0] = 1'b1;
        mPend[1] = 1'b1;
        mMag = (val < 0) ? -val : val;
        mDirLong = (val < 0);
        mVal = val;
        mDev[0] = 0;
        mDev[1] = 0;
      end
    end else begin
      wrEn = 1'b0;
      wrData = '0;
    end
  endtask

  task automatic waitIdle();
    int guard = 0;
    step(0, 0);
    while (modelBusy() && guard < 20000) begin
      step(0, 0);
      guard++;
    end
    repeat (60) step(0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired R7 actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h51e3));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 R2 R10 idle running
    repeat (120) step(0, 0);

    // R9 zero write
    step(1, 0);
    step(0, 0);
    chk(busy == 1'b0, "R9", busy, 0);
    repeat (100) step(0, 0);

    // R3 delay, R4 advance
    step(1, -3);
    waitIdle();
    step(1, 5);
    waitIdle();

    // R8 write during busy
    step(1, 4);
    repeat (10) step(0, 0);
    step(1, 9);
    step(0, 0);
    chk(busy == 1'b1, "R8", busy, 1);
    waitIdle();
    chk(doneDev[0] == -4, "R8", doneDev[0], -4);
    chk(doneDev[1] == -4, "R8", doneDev[1], -4);

    // R11 most negative value
    step(1, -128);
    waitIdle();
    chk(doneDev[0] == 128, "R11", doneDev[0], 128);
    chk(doneDev[1] == 128, "R11", doneDev[1], 128);

    // R4 largest positive
    step(1, 127);
    waitIdle();
    chk(doneDev[0] == doneDev[1], "R6", doneDev[0], doneDev[1]);

    // constrained random writes, some landing while busy (R8)
    for (int k = 0; k < 40; k++) begin
      int v;
      int gap;
      v = int'($urandom_range(40, 0)) - 20;
      gap = int'($urandom_range(300, 1));
      step(1, v);
      repeat (gap) step(0, 0);
    end
    waitIdle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule